// File: doc/BRIEF.md
# DRAM Bank Command Timing Enforcer

This block sits between the command scheduler of a memory controller and an SDRAM-style device. The scheduler presents one candidate command each cycle. Each command is a row open, a row close, a column read or a column write, and it names a bank. The block answers on the same cycle whether that command may legally go out. When the command is both valid and ready, the block records it and updates its per-bank row state and its spacing timers.

Every spacing limit arrives as a cycle count on an input port, so one build can serve several device speed grades. Typical values are 5 for activate-to-column, 5 for precharge-to-activate, 14 for activate-to-precharge, 19 for activate-to-activate in the same bank, 3 for activate-to-activate across banks, 3 for write-to-read and 5 for write recovery. A spacing of t cycles means that a command accepted in cycle n allows the dependent command in cycle n+t at the earliest. The block has no refresh, no mode programming, no data path and no address mapping.

Top module: `dram_cmd_gate`

## Requirements
- R1: After reset every bank is closed and every timer is idle. An activate to any bank is then ready, a read or write is not, and `bank_open` is all zero.
- R2: `cmd_type` is encoded 00 activate, 01 precharge, 10 read, 11 write. `cmd_ready` reports whether the presented command is legal whatever `cmd_valid` is, and a command changes state only in a cycle where both are high.
- R3: A bank holds at most one open row, and an activate to an open bank is never ready. An accepted activate sets that bank's `bank_open` bit from the next cycle on. From then on `sel_row` shows its row whenever `bank` addresses it.
- R4: A read or write to a closed bank is never ready. A read or write to an open bank waits `t_rcd` cycles after that bank's activate.
- R5: An activate waits `t_rp` cycles after that bank's last precharge.
- R6: A precharge waits `t_ras` cycles after that bank's activate and `t_wr` cycles after that bank's last write.
- R7: Two activates to the same bank are spaced by `t_rc` cycles. An activate to a bank other than the last activated one is spaced by `t_rrd` cycles from that activate.
- R8: A read to any bank waits `t_wtr` cycles after the most recent write to any bank.
- R9: A precharge to a closed bank is accepted as a no-op that still restarts that bank's `t_rp` wait.
- R10: A spacing value of 0 or 1 lets the dependent command go out in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Candidate command is to be issued |
| cmd_type | input | 2 | 00 activate, 01 precharge, 10 read, 11 write |
| bank | input | BW (2) | Bank the command addresses |
| row | input | RW (13) | Row captured by an activate |
| t_rcd | input | TW (5) | Activate to read/write spacing, cycles |
| t_rp | input | TW (5) | Precharge to activate spacing, cycles |
| t_ras | input | TW (5) | Activate to precharge spacing, cycles |
| t_rc | input | TW (5) | Activate to activate, same bank, cycles |
| t_rrd | input | TW (5) | Activate to activate, other bank, cycles |
| t_wtr | input | TW (5) | Write to read spacing, cycles |
| t_wr | input | TW (5) | Write to precharge spacing, cycles |
| cmd_ready | output | 1 | Presented command is legal this cycle (combinational) |
| bank_open | output | NB (4) | Registered per-bank open flag |
| sel_row | output | RW (13) | Open row of the addressed bank |

## Verification
`cmd_ready` is combinational, so the bench drives each candidate just after a falling edge and reads the answer a moment later in the same cycle. A command accepted at a rising edge loads its timers there. With spacing t, the dependent command reads not-ready for t-1 following cycles and ready in the t-th. The stimulus table encodes exactly those cycle offsets. `bank_open` and `sel_row` come from registers, so they are checked at least one falling edge after the accepting rising edge.

// File: rtl/dcg_pkg.sv
package dcg_pkg;
  typedef enum logic [1:0] {
    CMD_ACT = 2'b00,
    CMD_PRE = 2'b01,
    CMD_RD  = 2'b10,
    CMD_WR  = 2'b11
  } cmd_e;
endpackage

// File: rtl/dcg_sat_ctr.sv
// Saturating down-counter: loaded with span-1 on a trigger, counts to zero.
module dcg_sat_ctr #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] span,
  output logic         busy
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= (span == '0) ? '0 : span - ONE;
    else if (cnt != '0)
      cnt <= cnt - ONE;
  end

  assign busy = (cnt != '0);

  // R10: an idle counter stays idle unless reloaded
  p_idle_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !load) |=> !busy);

  // R10: a short span never produces a busy cycle
  p_short_span_r10: assert property (@(posedge clk) disable iff (rst)
    (load && span <= ONE) |=> !busy);
endmodule

// File: rtl/dcg_bank.sv
// Per-bank row state and same-bank spacing timers.
module dcg_bank #(
  parameter int TW = 5,
  parameter int RW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act_fire,
  input  logic          pre_fire,
  input  logic          wr_fire,
  input  logic [RW-1:0] row_i,
  input  logic [TW-1:0] t_rcd,
  input  logic [TW-1:0] t_rp,
  input  logic [TW-1:0] t_ras,
  input  logic [TW-1:0] t_rc,
  input  logic [TW-1:0] t_wr,
  output logic          open_o,
  output logic [RW-1:0] row_o,
  output logic          act_ok,
  output logic          pre_ok,
  output logic          col_ok
);
  logic rcd_busy, rp_busy, ras_busy, rc_busy, wr_busy;
  logic open_q;
  logic [RW-1:0] row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (act_fire) begin
      open_q <= 1'b1;
      row_q  <= row_i;
    end else if (pre_fire) begin
      open_q <= 1'b0;
    end
  end

  dcg_sat_ctr #(.W(TW)) u_rcd (.clk(clk), .rst(rst), .load(act_fire), .span(t_rcd), .busy(rcd_busy));
  dcg_sat_ctr #(.W(TW)) u_ras (.clk(clk), .rst(rst), .load(act_fire), .span(t_ras), .busy(ras_busy));
  dcg_sat_ctr #(.W(TW)) u_rc  (.clk(clk), .rst(rst), .load(act_fire), .span(t_rc),  .busy(rc_busy));
  dcg_sat_ctr #(.W(TW)) u_rp  (.clk(clk), .rst(rst), .load(pre_fire), .span(t_rp),  .busy(rp_busy));
  dcg_sat_ctr #(.W(TW)) u_wr  (.clk(clk), .rst(rst), .load(wr_fire),  .span(t_wr),  .busy(wr_busy));

  assign open_o = open_q;
  assign row_o  = row_q;
  assign act_ok = !open_q && !rp_busy && !rc_busy;
  assign pre_ok = !ras_busy && !wr_busy;
  assign col_ok = open_q && !rcd_busy;

  // R3: an accepted activate opens the bank and captures its row
  p_act_opens_r3: assert property (@(posedge clk) disable iff (rst)
    act_fire |=> (open_q && row_q == $past(row_i)));

  // R9: an accepted precharge leaves the bank closed
  p_pre_closes_r9: assert property (@(posedge clk) disable iff (rst)
    (pre_fire && !act_fire) |=> !open_q);

  // R4: a column command cannot follow an activate too soon
  p_rcd_gap_r4: assert property (@(posedge clk) disable iff (rst)
    (act_fire && t_rcd > 1) |=> !col_ok);

  // R6: write recovery holds off a precharge
  p_wr_gap_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && t_wr > 1) |=> !pre_ok);
endmodule

// File: rtl/dram_cmd_gate.sv
module dram_cmd_gate
  import dcg_pkg::*;
#(
  parameter int NB = 4,
  parameter int RW = 13,
  parameter int TW = 5,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_type,
  input  logic [BW-1:0] bank,
  input  logic [RW-1:0] row,
  input  logic [TW-1:0] t_rcd,
  input  logic [TW-1:0] t_rp,
  input  logic [TW-1:0] t_ras,
  input  logic [TW-1:0] t_rc,
  input  logic [TW-1:0] t_rrd,
  input  logic [TW-1:0] t_wtr,
  input  logic [TW-1:0] t_wr,
  output logic          cmd_ready,
  output logic [NB-1:0] bank_open,
  output logic [RW-1:0] sel_row
);
  cmd_e op;
  assign op = cmd_e'(cmd_type);

  logic fire;
  assign fire = cmd_valid && cmd_ready;

  logic [NB-1:0] act_ok_v, pre_ok_v, col_ok_v, open_v;
  logic [RW-1:0] row_v [NB];

  for (genvar i = 0; i < NB; i++) begin : g_bank
    localparam logic [BW-1:0] IDX = BW'(i);
    logic hit;
    assign hit = fire && (bank == IDX);

    dcg_bank #(.TW(TW), .RW(RW)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .act_fire(hit && op == CMD_ACT),
      .pre_fire(hit && op == CMD_PRE),
      .wr_fire (hit && op == CMD_WR),
      .row_i   (row),
      .t_rcd   (t_rcd),
      .t_rp    (t_rp),
      .t_ras   (t_ras),
      .t_rc    (t_rc),
      .t_wr    (t_wr),
      .open_o  (open_v[i]),
      .row_o   (row_v[i]),
      .act_ok  (act_ok_v[i]),
      .pre_ok  (pre_ok_v[i]),
      .col_ok  (col_ok_v[i])
    );
  end

  // Cross-bank timers
  logic rrd_busy, wtr_busy;
  logic [BW-1:0] last_act_q;

  dcg_sat_ctr #(.W(TW)) u_rrd (.clk(clk), .rst(rst), .load(fire && op == CMD_ACT), .span(t_rrd), .busy(rrd_busy));
  dcg_sat_ctr #(.W(TW)) u_wtr (.clk(clk), .rst(rst), .load(fire && op == CMD_WR),  .span(t_wtr), .busy(wtr_busy));

  always_ff @(posedge clk) begin
    if (rst)
      last_act_q <= '0;
    else if (fire && op == CMD_ACT)
      last_act_q <= bank;
  end

  always_comb begin
    unique case (op)
      CMD_ACT: cmd_ready = act_ok_v[bank] && (!rrd_busy || bank == last_act_q);
      CMD_PRE: cmd_ready = pre_ok_v[bank];
      CMD_RD:  cmd_ready = col_ok_v[bank] && !wtr_busy;
      CMD_WR:  cmd_ready = col_ok_v[bank];
      default: cmd_ready = 1'b0;
    endcase
  end

  assign bank_open = open_v;
  assign sel_row   = row_v[bank];

  // R3: never ready to activate a bank whose row is open
  p_one_row_r3: assert property (@(posedge clk) disable iff (rst)
    (op == CMD_ACT && cmd_ready) |-> !bank_open[bank]);

  // R4: column commands only to open banks
  p_col_open_r4: assert property (@(posedge clk) disable iff (rst)
    ((op == CMD_RD || op == CMD_WR) && cmd_ready) |-> bank_open[bank]);

  // R8: a write holds off the next read
  p_wtr_gap_r8: assert property (@(posedge clk) disable iff (rst)
    (fire && op == CMD_WR && t_wtr > 1) |=> !(op == CMD_RD && cmd_ready));

  // R7: cross-bank activate spacing
  p_rrd_gap_r7: assert property (@(posedge clk) disable iff (rst)
    (fire && op == CMD_ACT && t_rrd > 1) |=>
      !(op == CMD_ACT && cmd_ready && bank != $past(bank)));
endmodule

// File: tb/dram_cmd_gate_bench.sv
module dram_cmd_gate_bench;
  localparam int NB = 4;
  localparam int RW = 13;
  localparam int TW = 5;
  localparam int BW = 2;
  localparam int NV = 25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_type = 2'd0;
  logic [BW-1:0] bank = '0;
  logic [RW-1:0] row = '0;
  logic [TW-1:0] t_rcd, t_rp, t_ras, t_rc, t_rrd, t_wtr, t_wr;
  logic cmd_ready;
  logic [NB-1:0] bank_open;
  logic [RW-1:0] sel_row;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dram_cmd_gate #(.NB(NB), .RW(RW), .TW(TW)) u_dram_cmd_gate (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .bank(bank), .row(row), .t_rcd(t_rcd), .t_rp(t_rp), .t_ras(t_ras),
    .t_rc(t_rc), .t_rrd(t_rrd), .t_wtr(t_wtr), .t_wr(t_wr),
    .cmd_ready(cmd_ready), .bank_open(bank_open), .sel_row(sel_row)
  );

  // Encoding: 00 ACT, 01 PRE, 10 RD, 11 WR
  // Entry: {valid, type, bank, row, expected ready}, one per cycle
  // Spacings in use: rcd 2, rp 2, ras 4, rc 8, rrd 2, wtr 2, wr 3
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 2'd0, 2'd0, 13'd5,  1'b1},  //  0 R1 activate b0
    {1'b0, 2'd2, 2'd0, 13'd0,  1'b0},  //  1 R4 rcd blocks read
    {1'b1, 2'd0, 2'd1, 13'd7,  1'b1},  //  2 R7 rrd elapsed, activate b1
    {1'b0, 2'd0, 2'd2, 13'd0,  1'b0},  //  3 R7 rrd blocks b2
    {1'b1, 2'd3, 2'd0, 13'd0,  1'b1},  //  4 R4 write b0
    {1'b0, 2'd2, 2'd1, 13'd0,  1'b0},  //  5 R8 wtr blocks read b1
    {1'b0, 2'd1, 2'd0, 13'd0,  1'b0},  //  6 R6 write recovery
    {1'b1, 2'd1, 2'd0, 13'd0,  1'b1},  //  7 R6 precharge b0
    {1'b0, 2'd0, 2'd0, 13'd0,  1'b0},  //  8 R5 rp blocks
    {1'b1, 2'd0, 2'd0, 13'd9,  1'b1},  //  9 R5 activate b0 row 9
    {1'b0, 2'd0, 2'd0, 13'd0,  1'b0},  // 10 R3 bank already open
    {1'b0, 2'd2, 2'd3, 13'd0,  1'b0},  // 11 R4 closed bank read
    {1'b0, 2'd1, 2'd0, 13'd0,  1'b0},  // 12 R6 ras blocks
    {1'b1, 2'd1, 2'd0, 13'd0,  1'b1},  // 13 R6 precharge b0
    {1'b0, 2'd0, 2'd0, 13'd0,  1'b0},  // 14 R5 rp blocks
    {1'b0, 2'd0, 2'd0, 13'd0,  1'b0},  // 15 R7 rc blocks
    {1'b0, 2'd0, 2'd0, 13'd0,  1'b0},  // 16 R7 rc blocks
    {1'b1, 2'd0, 2'd0, 13'd3,  1'b1},  // 17 R7 rc elapsed, row 3
    {1'b0, 2'd2, 2'd0, 13'd0,  1'b0},  // 18 R4 rcd blocks
    {1'b1, 2'd1, 2'd2, 13'd0,  1'b1},  // 19 R9 precharge closed b2
    {1'b0, 2'd0, 2'd2, 13'd0,  1'b0},  // 20 R9 rp reloaded
    {1'b1, 2'd0, 2'd2, 13'd11, 1'b1},  // 21 R9 activate b2 row 11
    {1'b0, 2'd0, 2'd3, 13'd0,  1'b0},  // 22 R7 rrd blocks b3
    {1'b0, 2'd0, 2'd3, 13'd0,  1'b1},  // 23 R2 ready without valid
    {1'b0, 2'd2, 2'd3, 13'd0,  1'b0}   // 24 R2 b3 stayed closed
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic probe(input logic v, input logic [1:0] ty, input logic [BW-1:0] b,
                       input logic [RW-1:0] r, input logic exp, input string tag);
    @(negedge clk);
    cmd_valid = v; cmd_type = ty; bank = b; row = r;
    #1;
    check(tag, {31'd0, cmd_ready}, {31'd0, exp});
  endtask

  initial begin
    t_rcd = 5'd2; t_rp = 5'd2; t_ras = 5'd4; t_rc = 5'd8;
    t_rrd = 5'd2; t_wtr = 5'd2; t_wr = 5'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 bank_open after reset", {28'd0, bank_open}, 32'd0);
    probe(1'b0, 2'd0, 2'd2, '0, 1'b1, "R1 activate ready after reset");
    probe(1'b0, 2'd2, 2'd0, '0, 1'b0, "R1 read not ready after reset");
    probe(1'b0, 2'd3, 2'd1, '0, 1'b0, "R1 write not ready after reset");

    for (int i = 0; i < NV; i++) begin
      logic [18:0] e;
      e = VEC[i];
      probe(e[18], e[17:16], e[15:14], e[13:1], e[0], $sformatf("table step %0d", i));
    end

    @(negedge clk);
    cmd_valid = 1'b0; bank = 2'd0; #1;
    check("R3 bank_open after table", {28'd0, bank_open}, 32'h7);
    check("R3 sel_row bank0", {19'd0, sel_row}, 32'd3);
    bank = 2'd1; #1;
    check("R3 sel_row bank1", {19'd0, sel_row}, 32'd7);
    bank = 2'd2; #1;
    check("R3 sel_row bank2", {19'd0, sel_row}, 32'd11);

    // R10: zero spacing
    t_rcd = 5'd0; t_rp = 5'd0; t_ras = 5'd0; t_rc = 5'd1;
    t_rrd = 5'd0; t_wtr = 5'd1; t_wr = 5'd0;
    repeat (12) @(negedge clk);
    probe(1'b1, 2'd0, 2'd3, 13'd21, 1'b1, "R10 activate b3");
    probe(1'b1, 2'd3, 2'd3, '0, 1'b1, "R10 write right after activate");
    probe(1'b0, 2'd2, 2'd3, '0, 1'b1, "R10 read right after write");
    probe(1'b1, 2'd1, 2'd3, '0, 1'b1, "R10 precharge right after write");
    probe(1'b0, 2'd0, 2'd3, '0, 1'b1, "R10 activate right after precharge");

    // R1: reset in mid-operation
    @(negedge clk);
    cmd_valid = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 bank_open after second reset", {28'd0, bank_open}, 32'd0);
    probe(1'b0, 2'd2, 2'd1, '0, 1'b0, "R1 read to reset bank");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule